// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the software-visible registers for one DMA channel that serves a SCSI-style peripheral. It has four 32-bit words on a simple single-cycle read/write bus: a control/status word, a running memory address, a general word, and a base/high-address word. The memory mastering engine, the FIFO and the address translation sit outside the block. The engine reports each finished transfer over a small valid/ready port that carries the byte count. The block adds that count to the running address.

The block combines an interrupt request from the peripheral with the enable bit that software sets. It drives the CPU interrupt line from that result. When software writes the control word with the reset command bit set, the block issues a one-cycle reset pulse to the peripheral. A fixed version code sits in the top nibble of the control word.

The transfer port never applies back-pressure: `xfer_ready` is tied high. Every cycle in which `xfer_valid` is high counts as one completed transfer, and `xfer_len` must be valid in that cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: The word index is `bus_addr[3:2]`, and `bus_addr[1:0]` is ignored. Index 0 is control/status, index 1 is the running address, index 2 is a plain read/write word, and index 3 is the base word. A write with `bus_we` high updates the selected word at the clock edge. `bus_rdata` always shows the selected word.
- R2: After reset, the control word reads 0xA0000000 and the other three words read zero. `cpu_irq` and `periph_rst` are low.
- R3: Control bits [31:28] always read 0xA. Writes do not change them.
- R4: A control write with bit 7 (reset command) set drives `periph_rst` high for exactly the one cycle after the write edge. Bit 7 reads back as written.
- R5: Bit 6 (drain command) reads back as zero after a control write that has bit 7 clear. It is kept as written when bit 7 is also set.
- R6: A write to index 1 sets bit 26 (address loaded) of the control word. A control write stores bit 26 as written.
- R7: Each cycle with `xfer_valid` high adds `xfer_len` (zero-extended) to the running address. It also sets bit 0 (interrupt pending) of the control word.
- R8: If an index-1 write and a transfer occur in the same cycle, the running address becomes the written value plus `xfer_len`.
- R9: A rising edge on `periph_irq` sets bit 0, and a falling edge clears it. A transfer in the same cycle as a falling edge keeps bit 0 set.
- R10: `cpu_irq` is high exactly while control bit 0 and bit 4 (interrupt enable) are both set. It drops in the cycle after a control write that clears bit 4.
- R11: Software writes do not change control bit 0.
- R12: Bit 8 (direction, toward memory) and the other control bits in [27:1] store and read back as written, apart from bits 6 and 26 as stated above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the selected word |
| bus_addr | input | ADDR_W (4) | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Selected word (combinational) |
| xfer_valid | input | 1 | Transfer completed this cycle |
| xfer_ready | output | 1 | Always high; the port never stalls |
| xfer_len | input | LEN_W (16) | Byte count of the completed transfer |
| periph_irq | input | 1 | Interrupt request level from the peripheral |
| cpu_irq | output | 1 | Interrupt line to the CPU |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
Every register effect appears one clock edge after its cause. A bus write, a transfer or a `periph_irq` edge at edge k shows on `bus_rdata` and `cpu_irq` just after edge k, and `periph_rst` is high for the cycle that follows edge k. The bench drives inputs, waits for the rising edge, then advances a behavioural model. It compares the read data, the interrupt line and the reset pulse at the falling edge of the same cycle. This places each comparison exactly one edge after its stimulus, with no allowance for early or late results. The directed sequence covers write/transfer collisions, back-to-back reset commands, and a falling edge on `periph_irq` that coincides with a transfer.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int WORD_W     = 32;
  localparam int PEND_BIT   = 0;
  localparam int IEN_BIT    = 4;
  localparam int DRAIN_BIT  = 6;
  localparam int RST_BIT    = 7;
  localparam int DIR_BIT    = 8;
  localparam int LOADED_BIT = 26;
  localparam int VER_LSB    = 28;
  localparam logic [WORD_W-VER_LSB-1:0] VER_VAL = 4'hA;
  localparam logic [WORD_W-1:0] CTRL_RST_VAL = {VER_VAL, {VER_LSB{1'b0}}};

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_ADDR = 2'd1,
    IDX_AUX  = 2'd2,
    IDX_BASE = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_wr,
  input  logic [VER_LSB-1:1]     wfield,
  input  logic                   addr_wr,
  input  logic                   xfer_fire,
  input  logic                   periph_irq,
  output logic [WORD_W-1:0]      ctrl_word,
  output logic                   cpu_irq,
  output logic                   periph_rst
);
  logic [VER_LSB-1:1] cfg_q;
  logic [VER_LSB-1:1] cfg_wr;
  logic pend_q, pirq_q, rst_q;
  logic irq_rise, irq_fall;

  // drain command only persists when paired with the reset command
  always_comb begin
    cfg_wr = wfield;
    if (!wfield[RST_BIT] && wfield[DRAIN_BIT]) cfg_wr[DRAIN_BIT] = 1'b0;
  end

  assign irq_rise = periph_irq & ~pirq_q;
  assign irq_fall = ~periph_irq & pirq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      pirq_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (ctrl_wr)      cfg_q <= cfg_wr;
      else if (addr_wr) cfg_q[LOADED_BIT] <= 1'b1;
      if (xfer_fire || irq_rise) pend_q <= 1'b1;
      else if (irq_fall)         pend_q <= 1'b0;
      pirq_q <= periph_irq;
      rst_q  <= ctrl_wr & wfield[RST_BIT];
    end
  end

  assign ctrl_word  = {VER_VAL, cfg_q, pend_q};
  assign cpu_irq    = pend_q & cfg_q[IEN_BIT];
  assign periph_rst = rst_q;
endmodule

// File: rtl/dcr_addr.sv
module dcr_addr
  import dcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fire,
  input  logic [WORD_W-1:0] len,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] start;
  logic [WORD_W-1:0] step;

  assign start = wr ? wdata : q;
  assign step  = fire ? len : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= start + step;
  end
endmodule

// File: rtl/dcr_word.sv
module dcr_word
  import dcr_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              periph_irq,
  output logic              cpu_irq,
  output logic              periph_rst
);
  localparam int IDX_LSB = 2;
  localparam int N_WORDS = 4;

  reg_idx_e          idx;
  logic              unused_addr_bits;
  logic              xfer_fire;
  logic [WORD_W-1:0] len_ext;
  logic [WORD_W-1:0] ctrl_word;
  logic [WORD_W-1:0] addr_word;
  logic [WORD_W-1:0] plain_q [IDX_AUX:N_WORDS-1];

  assign idx              = reg_idx_e'(bus_addr[IDX_LSB+1:IDX_LSB]);
  assign unused_addr_bits = ^{bus_addr[IDX_LSB-1:0], bus_addr[ADDR_W-1:IDX_LSB]};
  assign xfer_ready       = 1'b1;
  assign xfer_fire        = xfer_valid & xfer_ready;
  assign len_ext          = WORD_W'(xfer_len);

  dcr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (bus_we && idx == IDX_CTRL),
    .wfield     (bus_wdata[VER_LSB-1:1]),
    .addr_wr    (bus_we && idx == IDX_ADDR),
    .xfer_fire  (xfer_fire),
    .periph_irq (periph_irq),
    .ctrl_word  (ctrl_word),
    .cpu_irq    (cpu_irq),
    .periph_rst (periph_rst)
  );

  dcr_addr u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_we && idx == IDX_ADDR),
    .wdata (bus_wdata),
    .fire  (xfer_fire),
    .len   (len_ext),
    .q     (addr_word)
  );

  for (genvar g = IDX_AUX; g < N_WORDS; g++) begin : g_plain
    dcr_word u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_we && idx == reg_idx_e'(g)),
      .wdata (bus_wdata),
      .q     (plain_q[g])
    );
  end

  always_comb begin
    unique case (idx)
      IDX_CTRL: bus_rdata = ctrl_word;
      IDX_ADDR: bus_rdata = addr_word;
      IDX_AUX:  bus_rdata = plain_q[IDX_AUX];
      default:  bus_rdata = plain_q[IDX_BASE];
    endcase
  end
endmodule

// File: rtl/dcr_chk.sv
module dcr_chk
  import dcr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        widx,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              xfer_valid,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              periph_irq,
  input logic              cpu_irq,
  input logic              periph_rst,
  input logic [WORD_W-1:0] ctrl_word,
  input logic [WORD_W-1:0] addr_word
);
  logic ctrl_wr, addr_wr;
  assign ctrl_wr = bus_we && widx == 2'd0;
  assign addr_wr = bus_we && widx == 2'd1;

  assert_version_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[31:28] == VER_VAL);

  assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> periph_rst == $past(ctrl_wr && bus_wdata[RST_BIT]));

  assert_drain_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[RST_BIT] && bus_wdata[DRAIN_BIT]) |=> !ctrl_word[DRAIN_BIT]);

  assert_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ctrl_word[LOADED_BIT]);

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !addr_wr) |=> addr_word == $past(addr_word) + WORD_W'($past(xfer_len)));

  assert_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && addr_wr) |=> addr_word == $past(bus_wdata) + WORD_W'($past(xfer_len)));

  assert_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_irq) |=> ctrl_word[PEND_BIT]);

  assert_ien_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[IEN_BIT]) |=> !cpu_irq);

  assert_pend_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !xfer_valid && periph_irq == $past(periph_irq)) |=>
      ctrl_word[PEND_BIT] == $past(ctrl_word[PEND_BIT]));
endmodule

bind dma_chan_regs dcr_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .widx       (bus_addr[3:2]),
  .bus_wdata  (bus_wdata),
  .xfer_valid (xfer_valid),
  .xfer_len   (xfer_len),
  .periph_irq (periph_irq),
  .cpu_irq    (cpu_irq),
  .periph_rst (periph_rst),
  .ctrl_word  (ctrl_word),
  .addr_word  (addr_word)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic [15:0] xfer_len = '0;
  logic        periph_irq = 1'b0;
  logic        cpu_irq, periph_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_reg [4];
  logic        m_prev_irq;
  logic        m_rst;

  always #5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_len(xfer_len), .periph_irq(periph_irq),
    .cpu_irq(cpu_irq), .periph_rst(periph_rst)
  );

  task automatic model_reset();
    m_reg[0] = 32'hA000_0000;
    m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
    m_prev_irq = 1'b0;
    m_rst = 1'b0;
  endtask

  task automatic model_edge();
    int i;
    logic [31:0] w;
    logic pend;
    i = int'(bus_addr[3:2]);
    pend = m_reg[0][0];
    m_rst = bus_we && i == 0 && bus_wdata[7];
    if (!periph_irq && m_prev_irq) pend = 1'b0;
    if (periph_irq && !m_prev_irq) pend = 1'b1;
    if (xfer_valid) pend = 1'b1;
    if (bus_we) begin
      if (i == 0) begin
        w = bus_wdata;
        if (!w[7] && w[6]) w[6] = 1'b0;
        m_reg[0] = {4'hA, w[27:1], 1'b0};
      end else if (i == 1) begin
        m_reg[1] = bus_wdata;
        m_reg[0][26] = 1'b1;
      end else begin
        m_reg[i] = bus_wdata;
      end
    end
    if (xfer_valid) m_reg[1] = m_reg[1] + 32'(xfer_len);
    m_reg[0][0] = pend;
    m_prev_irq = periph_irq;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, clock edge, advance model, compare at falling edge
  task automatic step(input string tag, input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic xv, input logic [15:0] len, input logic pi);
    bus_we = we; bus_addr = a; bus_wdata = d; xfer_valid = xv; xfer_len = len; periph_irq = pi;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "rdata", bus_rdata, m_reg[int'(a[3:2])]);
    check(tag, "cpu_irq", 32'(cpu_irq), 32'(m_reg[0][0] & m_reg[0][4]));
    check(tag, "periph_rst", 32'(periph_rst), 32'(m_rst));
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic pi);
    step(tag, 1'b0, a, 32'h0, 1'b0, 16'h0, pi);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset values of every word and of the outputs
    check("R2", "ready", 32'(xfer_ready), 32'h1);
    for (int k = 0; k < 4; k++) rd("R2", 4'(k * 4), 1'b0);
    // R1: plain word, base word, low address bits ignored
    step("R1", 1'b1, 4'h8, 32'h1234_5678, 1'b0, 16'h0, 1'b0);
    step("R1", 1'b1, 4'hF, 32'hDEAD_0000, 1'b0, 16'h0, 1'b0);
    rd("R1", 4'hA, 1'b0);
    rd("R1", 4'hC, 1'b0);
    // R3 R4 R11 R12: all ones, reset command set, drain kept, version fixed
    step("R4", 1'b1, 4'h0, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0);
    rd("R3", 4'h0, 1'b0);
    step("R11", 1'b1, 4'h0, 32'h0000_0101, 1'b0, 16'h0, 1'b0);
    rd("R12", 4'h0, 1'b0);
    // R5: drain without reset command is dropped
    step("R5", 1'b1, 4'h0, 32'h0000_0050, 1'b0, 16'h0, 1'b0);
    rd("R5", 4'h0, 1'b0);
    // R6: address write sets loaded flag
    step("R6", 1'b1, 4'h4, 32'h0000_1000, 1'b0, 16'h0, 1'b0);
    rd("R6", 4'h0, 1'b0);
    // R7 R10: transfer advances address, pending + enable raises interrupt
    step("R7", 1'b0, 4'h4, 32'h0, 1'b1, 16'h0020, 1'b0);
    rd("R10", 4'h0, 1'b0);
    step("R10", 1'b1, 4'h0, 32'h0000_0000, 1'b0, 16'h0, 1'b0);
    rd("R10", 4'h0, 1'b0);
    step("R10", 1'b1, 4'h0, 32'h0000_0010, 1'b0, 16'h0, 1'b0);
    // R9: peripheral level edges
    step("R9", 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, 1'b1);
    rd("R9", 4'h0, 1'b1);
    step("R9", 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, 1'b0);
    rd("R9", 4'h0, 1'b0);
    step("R9", 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, 1'b1);
    step("R9", 1'b0, 4'h4, 32'h0, 1'b1, 16'h0003, 1'b0);
    rd("R9", 4'h0, 1'b0);
    // R8: address write and transfer in the same cycle
    step("R8", 1'b1, 4'h4, 32'h0000_2000, 1'b1, 16'h0008, 1'b0);
    rd("R8", 4'h4, 1'b0);
    step("R8", 1'b1, 4'h4, 32'hFFFF_FFF0, 1'b1, 16'hFFFF, 1'b0);
    // R7: back-to-back transfers of varied length, including zero
    for (int k = 0; k < 8; k++) step("R7", 1'b0, 4'h4, 32'h0, 1'b1, 16'(k * 37 + (k == 3 ? 0 : 1)), 1'b0);
    step("R7", 1'b0, 4'h4, 32'h0, 1'b1, 16'h0000, 1'b0);
    // R4: back-to-back reset commands, then a quiet cycle
    step("R4", 1'b1, 4'h0, 32'h0000_00C0, 1'b0, 16'h0, 1'b0);
    step("R4", 1'b1, 4'h0, 32'h0000_0080, 1'b0, 16'h0, 1'b0);
    rd("R4", 4'h0, 1'b0);
    rd("R4", 4'h0, 1'b0);
    // R6: control write clears loaded flag as written
    step("R6", 1'b1, 4'h0, 32'h0000_0010, 1'b0, 16'h0, 1'b0);
    rd("R6", 4'h0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule